// File: doc/BRIEF.md
# Split-Mode Hard Multiplier

This block is a multiplier of the kind built into a chip as a fixed resource. It takes two 18-bit operands. It works in one of two arrangements, chosen by a mode input that is held steady during use. In the wide arrangement it forms a single 36-bit product. In the split arrangement the same datapath forms two unrelated 9x9 products, packed side by side on the 36-bit result.

Each operand has its own flag that marks it as signed (two's complement) or unsigned. Any mix of the two is allowed, so a signed coefficient can scale an unsigned sample directly. The same bit pattern can therefore produce very different products.

Two build parameters set whether the operands are captured in registers and whether the result is registered. The default build registers both. In that build, one clock enable advances every stage at once, and a synchronous clear empties them all. A valid flag moves along the pipeline with the data.

Top module: `split_mult`

## Requirements
- R1: With `splitMode` = 0 and both sign flags 0, `prodOut[35:0]` is the unsigned product of `opA` and `opB`. For example, 3FFFF times 3FFFF gives F_FFF8_0001.
- R2: A sign flag of 1 marks its operand as two's complement, and a flag of 0 marks it as unsigned. Each flag acts alone. In wide mode the 36-bit result is two's complement whenever either flag is 1. For example, all-ones times all-ones gives 1 when both flags are 1.
- R3: With `splitMode` = 1, bits [8:0] of both operands form a product on `prodOut[17:0]`. Bits [17:9] of both operands form a separate product on `prodOut[35:18]`. Neither lane affects the other.
- R4: In split mode, `signA` applies to both 9-bit halves of `opA`, and `signB` applies to both halves of `opB`. For example, 1FF times 1FF gives 00001 in a lane when both flags are 1 and 3FC01 when both are 0.
- R5: In the default build, the operands present at a rising edge with `en` = 1 appear as a product after exactly the second such edge. After the first edge the output still shows the older result.
- R6: On an edge with `en` = 0 and `sClr` = 0, no register changes. `prodOut` and `prodValid` keep their values even while the inputs change.
- R7: `sClr` = 1 at a rising edge sets `prodOut` to 0 and `prodValid` to 0 on that edge, whatever the value of `en`.
- R8: `prodValid` becomes 1 after two enabled edges that follow a clear. It stays 1 until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| en | input | 1 | Clock enable for every pipeline stage |
| sClr | input | 1 | Synchronous clear of data and valid registers |
| opA | input | 18 | Operand A (two 9-bit halves in split mode) |
| opB | input | 18 | Operand B (two 9-bit halves in split mode) |
| splitMode | input | 1 | 0: one 18x18 product, 1: two 9x9 products |
| signA | input | 1 | 1: operand A is two's complement, 0: unsigned |
| signB | input | 1 | 1: operand B is two's complement, 0: unsigned |
| prodOut | output | 36 | Product, or two 18-bit products in split mode |
| prodValid | output | 1 | Result on `prodOut` comes from captured operands |

## Verification
The hardest situation to reach from the ports is a stalled pipeline whose two stages hold results of different kinds. One example is a split, signed result waiting behind a wide, unsigned one while the inputs keep changing. Random stimulus holds `en` low on about a quarter of edges and changes mode and both flags on every cycle, so mixed stage contents are frozen and then released often. Directed cases add the extreme bit patterns, such as all-ones and the most negative value in each signedness mix, and a clear issued while `en` is high.

// File: rtl/split_mult_pkg.sv
package split_mult_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic advance;  // every stage loads on this edge
    logic flush;    // every stage is zeroed on this edge
  } stepCtrl_t;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } mulMode_e;

endpackage

// File: rtl/split_mult_lane.sv
// One multiplier lane. Each operand is widened by one bit, taking the sign
// bit or a zero as its flag says. One signed multiply then covers all four
// sign combinations. Only the low 2*W bits are formed.
module split_mult_lane #(
  parameter int W = 9
) (
  input  logic [W-1:0]   xIn,
  input  logic [W-1:0]   yIn,
  input  logic           xSigned,
  input  logic           ySigned,
  output logic [2*W-1:0] pOut
);
  localparam int PW = 2 * W;

  logic [W:0]           xExt;
  logic [W:0]           yExt;
  logic signed [PW-1:0] xWide;
  logic signed [PW-1:0] yWide;
  logic signed [PW-1:0] prodWide;

  always_comb begin
    xExt     = {xSigned & xIn[W-1], xIn};
    yExt     = {ySigned & yIn[W-1], yIn};
    xWide    = {{(W-1){xExt[W]}}, xExt};
    yWide    = {{(W-1){yExt[W]}}, yExt};
    prodWide = xWide * yWide;
    pOut     = prodWide;
  end

endmodule

// File: rtl/split_mult_ctrl.sv
module split_mult_ctrl
  import split_mult_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic      clk,
  input  logic      en,
  input  logic      sClr,
  output stepCtrl_t ctl,
  output logic      validOut
);

  always_comb begin
    ctl.flush   = sClr;
    ctl.advance = en & ~sClr;
  end

  generate
    if (LAT == 0) begin : g_comb
      assign validOut = en;
    end else begin : g_pipe
      logic [LAT-1:0] vld;
      logic           armed;

      always_ff @(posedge clk) begin
        if (ctl.flush) begin
          vld <= '0;
        end else if (ctl.advance) begin
          vld <= LAT'({vld, 1'b1});
        end
      end
      assign validOut = vld[LAT-1];

      // Assertion-only: set once the first clear has been seen.
      always_ff @(posedge clk) begin
        armed <= (armed === 1'b1) | sClr;
      end

      // R7: a clear drops the valid flag on the same edge.
      p_clear_valid_r7: assert property (@(posedge clk)
        sClr |=> !validOut);

      // R6: a stalled edge keeps the valid flag.
      p_hold_valid_r6: assert property (@(posedge clk) disable iff (sClr)
        (armed && !en) |=> $stable(validOut));

      // R8: once valid, enabled edges without a clear keep it valid.
      p_valid_stays_r8: assert property (@(posedge clk) disable iff (sClr)
        (armed && validOut) |=> validOut);
    end
  endgenerate

endmodule

// File: rtl/split_mult_dp.sv
module split_mult_dp
  import split_mult_pkg::*;
#(
  parameter int OP_W    = 18,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  stepCtrl_t       ctl,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  input  logic            splitMode,
  input  logic            signA,
  input  logic            signB,
  output logic [2*OP_W-1:0] prodOut
);
  localparam int HALF  = OP_W / 2;
  localparam int PW    = 2 * OP_W;
  localparam int LANES = 2;

  logic [OP_W-1:0] aQ, bQ;
  logic            splitQ, sgnAQ, sgnBQ;

  // Operand stage
  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk) begin
        if (ctl.flush) begin
          aQ <= '0; bQ <= '0; splitQ <= 1'b0; sgnAQ <= 1'b0; sgnBQ <= 1'b0;
        end else if (ctl.advance) begin
          aQ <= opA; bQ <= opB; splitQ <= splitMode; sgnAQ <= signA; sgnBQ <= signB;
        end
      end
    end else begin : g_in_pass
      always_comb begin
        aQ = opA; bQ = opB; splitQ = splitMode; sgnAQ = signA; sgnBQ = signB;
      end
    end
  endgenerate

  // Multiply core: one wide lane plus two narrow lanes
  logic [PW-1:0]   wideP;
  logic [OP_W-1:0] narrowP [LANES];
  logic [PW-1:0]   prodNext;

  split_mult_lane #(.W(OP_W)) u_wide (
    .xIn(aQ), .yIn(bQ), .xSigned(sgnAQ), .ySigned(sgnBQ), .pOut(wideP)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_narrow
      split_mult_lane #(.W(HALF)) u_lane (
        .xIn(aQ[g*HALF +: HALF]), .yIn(bQ[g*HALF +: HALF]),
        .xSigned(sgnAQ), .ySigned(sgnBQ), .pOut(narrowP[g])
      );
    end
  endgenerate

  always_comb begin
    if (mulMode_e'(splitQ) == MODE_SPLIT) prodNext = {narrowP[1], narrowP[0]};
    else                                  prodNext = wideP;
  end

  // Result stage
  generate
    if (OUT_REG) begin : g_out_reg
      logic [PW-1:0] outQ;
      logic          armed;

      always_ff @(posedge clk) begin
        if (ctl.flush)        outQ <= '0;
        else if (ctl.advance) outQ <= prodNext;
      end
      assign prodOut = outQ;

      always_ff @(posedge clk) begin
        armed <= (armed === 1'b1) | ctl.flush;
      end

      // R7: the product register is zero after a clear edge.
      p_clear_prod_r7: assert property (@(posedge clk)
        ctl.flush |=> (prodOut == '0));

      // R6: no advance strobe means the product does not move.
      p_hold_prod_r6: assert property (@(posedge clk) disable iff (ctl.flush)
        (armed && !ctl.advance) |=> $stable(prodOut));
    end else begin : g_out_pass
      assign prodOut = prodNext;
    end
  endgenerate

endmodule

// File: rtl/split_mult.sv
module split_mult
  import split_mult_pkg::*;
#(
  parameter int OP_W    = 18,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              en,
  input  logic              sClr,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              splitMode,
  input  logic              signA,
  input  logic              signB,
  output logic [2*OP_W-1:0] prodOut,
  output logic              prodValid
);
  localparam int LAT = int'(IN_REG) + int'(OUT_REG);

  stepCtrl_t ctl;

  split_mult_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .en(en), .sClr(sClr), .ctl(ctl), .validOut(prodValid)
  );

  split_mult_dp #(.OP_W(OP_W), .IN_REG(IN_REG), .OUT_REG(OUT_REG)) u_dp (
    .clk(clk), .ctl(ctl), .opA(opA), .opB(opB), .splitMode(splitMode),
    .signA(signA), .signB(signB), .prodOut(prodOut)
  );

endmodule

// File: tb/split_mult_test.sv
module split_mult_test;
  logic        clk = 1'b0;
  logic        en = 1'b0, sClr = 1'b1;
  logic [17:0] opA = '0, opB = '0;
  logic        splitMode = 1'b0, signA = 1'b0, signB = 1'b0;
  logic [35:0] prodOut;
  logic        prodValid;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  split_mult uut (.*);

  function automatic longint extv(logic [17:0] v, int w, bit s);
    longint r = 0;
    for (int i = 0; i < w; i++) r[i] = v[i];
    if (s && v[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic logic [35:0] refProd(bit sp, bit sa, bit sb, logic [17:0] a, logic [17:0] b);
    longint p, p0, p1;
    if (!sp) begin
      p = extv(a, 18, sa) * extv(b, 18, sb);
      return 36'(p);
    end
    p0 = extv({9'd0, a[8:0]}, 9, sa) * extv({9'd0, b[8:0]}, 9, sb);
    p1 = extv({9'd0, a[17:9]}, 9, sa) * extv({9'd0, b[17:9]}, 9, sb);
    return {18'(p1), 18'(p0)};
  endfunction

  function automatic string tagOf(bit sp, bit sa, bit sb);
    if (!sp) return (sa | sb) ? "R2" : "R1";
    return (sa | sb) ? "R4" : "R3";
  endfunction

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model: two stages of expected values
  logic [35:0] s0Exp = '0, oExp = '0;
  bit          s0V = 0, oV = 0, armed = 0;
  string       s0Tag = "R7", oTag = "R7";

  always @(posedge clk) begin
    if (sClr) begin
      s0Exp <= '0; s0V <= 0; oExp <= '0; oV <= 0; s0Tag <= "R7"; oTag <= "R7"; armed <= 1;
    end else if (en) begin
      s0Exp <= refProd(splitMode, signA, signB, opA, opB);
      s0V   <= 1;
      s0Tag <= tagOf(splitMode, signA, signB);
      oExp  <= s0Exp; oV <= s0V; oTag <= s0Tag;
    end else begin
      oTag <= "R6";
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(prodOut === oExp, oTag, prodOut, oExp);
      chk(prodValid === oV, "R8", {35'd0, prodValid}, {35'd0, oV});
    end
  end

  task automatic drive(bit e, bit c, bit sp, bit sa, bit sb, logic [17:0] a, logic [17:0] b);
    en = e; sClr = c; splitMode = sp; signA = sa; signB = sb; opA = a; opB = b;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk(prodOut === '0 && prodValid === 1'b0, "R7", prodOut, 36'd0);
    // R5: latency of exactly two enabled edges
    drive(1, 0, 0, 0, 0, 18'd3, 18'd5);
    step(1);
    chk(prodOut === 36'd0, "R5", prodOut, 36'd0);
    step(1);
    chk(prodOut === 36'd15, "R5", prodOut, 36'd15);
    // R1 / R2 corner values in wide mode
    drive(1, 0, 0, 0, 0, 18'h3FFFF, 18'h3FFFF); step(1);
    drive(1, 0, 0, 1, 1, 18'h3FFFF, 18'h3FFFF); step(1);
    chk(prodOut === 36'hFFFF80001, "R1", prodOut, 36'hFFFF80001);
    drive(1, 0, 0, 1, 0, 18'h3FFFF, 18'h3FFFF); step(1);
    chk(prodOut === 36'd1, "R2", prodOut, 36'd1);
    drive(1, 0, 0, 1, 1, 18'h20000, 18'h20000); step(1);
    chk(prodOut === 36'hFFFFC0001, "R2", prodOut, 36'hFFFFC0001);
    // R3 / R4 split mode
    drive(1, 0, 1, 0, 0, 18'h3FFFF, 18'h3FFFF); step(1);
    chk(prodOut === 36'h400000000, "R2", prodOut, 36'h400000000);
    drive(1, 0, 1, 1, 1, 18'h3FFFF, 18'h3FFFF); step(1);
    chk(prodOut === {18'h3FC01, 18'h3FC01}, "R3", prodOut, {18'h3FC01, 18'h3FC01});
    drive(1, 0, 1, 0, 0, {9'd7, 9'd2}, {9'd3, 9'd100}); step(1);
    chk(prodOut === {18'd1, 18'd1}, "R4", prodOut, {18'd1, 18'd1});
    step(1);
    chk(prodOut === {18'd21, 18'd200}, "R3", prodOut, {18'd21, 18'd200});
    // R6: stall with changing inputs
    drive(0, 0, 0, 1, 0, 18'h12345, 18'h00777); step(1);
    drive(0, 0, 1, 0, 1, 18'h2AAAA, 18'h15555); step(2);
    chk(prodOut === {18'd21, 18'd200}, "R6", prodOut, {18'd21, 18'd200});
    // R7: clear wins over enable
    drive(1, 1, 0, 0, 0, 18'd9, 18'd9); step(1);
    chk(prodOut === '0 && prodValid === 1'b0, "R7", prodOut, 36'd0);
    // R8: valid returns after two enabled edges
    drive(1, 0, 0, 0, 0, 18'd2, 18'd2); step(1);
    chk(prodValid === 1'b0, "R8", {35'd0, prodValid}, 36'd0);
    step(1);
    chk(prodValid === 1'b1, "R8", {35'd0, prodValid}, 36'd1);
    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) != 0, ($urandom % 60) == 0, $urandom % 2, $urandom % 2,
            $urandom % 2, 18'($urandom), 18'($urandom));
      step(1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule